// File: doc/BRIEF.md
# Parallel PRBS Pattern Verifier

This block watches a stream of parallel received words and decides whether they follow a pseudo-random binary sequence. It starts with no knowledge of where the pattern is. It takes its starting point from the low bits of an incoming word and predicts the next word from them. When enough predictions in a row come true, it treats the stream as locked. It then spends one whole sequence period confirming the match before it raises its done flag.

Once done is set, the predictor stops taking its state from the data and runs on its own. Every valid word is compared with the free-running prediction. A word that differs in any number of bits produces one error pulse three clock cycles long. A clear request discards all tracking state, drops done, and forces a new lock. The polynomial, the word width, the lock depth and the pulse length are parameters. The defaults are x^7+x^6+1 on 32-bit words.

Top module: `prbs_verifier`

## Requirements
- R1: After reset, done_o and error_o are both 0.
- R2: Within a word, data_i[W-1] is the earliest bit and data_i[0] the latest. Each bit equals the XOR of the bits 7 and 6 positions earlier in the stream. With the defaults, done_o rises in the cycle after the 9th consecutive good valid word is sampled: 1 seed word, 4 lock words and 4 words covering the 127-bit period.
- R3: A mismatching word before lock restarts acquisition. That word becomes the new seed, and 8 further good words are needed before done_o rises.
- R4: A mismatching word after lock but before done_o also restarts acquisition in the same way as R3. It needs 8 further good words and raises no error.
- R5: error_o is never 1 while done_o is 0.
- R6: After done_o is set, an errored valid word makes error_o 1 for exactly 3 cycles, starting in the cycle after the word is sampled.
- R7: A word with any number of wrong bits gives a single 3-cycle pulse. Good words that follow give no further error, because the predictor does not reseed from the bad word.
- R8: An errored word that arrives while a pulse is active restarts the pulse at 3 cycles.
- R9: Words with valid_i low are ignored. They do not change lock progress, the prediction or the error state.
- R10: clear_i drops done_o and error_o in the next cycle. A fresh lock of 9 good words is then needed.
- R11: A valid word presented in the same cycle as clear_i is discarded and does not count as a seed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Parallel word clock |
| rst_n | input | 1 | Synchronous reset, active low |
| valid_i | input | 1 | Qualifies data_i for this cycle |
| data_i | input | W (32) | Received parallel word, MSB earliest |
| clear_i | input | 1 | Discard tracking state and restart lock |
| done_o | output | 1 | One full period verified |
| error_o | output | 1 | Stretched pulse per errored word |

## Verification
Each result appears exactly one clock edge after the word that causes it. done_o changes in the cycle after the ninth good word, or after the eighth word that follows a reseed. error_o is high during the first three cycles after an errored word, and clear_i takes effect after one edge. The bench drives each word on the falling edge and reads the outputs 1 ns after the next rising edge. Every expected value therefore lines up with the edge that sampled its word. Pulses are checked cycle by cycle with idle cycles in between, so that both the start and the end of each pulse are observed.

// File: rtl/prbs_pkg.sv
// Package: shared types for the parallel PRBS verifier.
// Assumes nothing beyond IEEE 1800-2017.
package prbs_pkg;
    // Tracking phase of the verifier
    typedef enum logic [1:0] {
        PH_HUNT  = 2'd0,   // seeding from data, counting matches
        PH_SWEEP = 2'd1,   // locked, walking one full period
        PH_DONE  = 2'd2    // period verified, predictor free-running
    } phase_t;
endpackage

// File: rtl/prbs_predictor.sv
// Module: prbs_predictor
// Purpose: combinational unroll of a Fibonacci LFSR across one word.
// Given the last ORDER bits of the stream (bit 0 newest), it produces the
// next WIDTH bits, with the earliest bit at the MSB.
// Assumes WIDTH >= ORDER so the next state is the low ORDER bits of the word.
module prbs_predictor #(
    parameter int ORDER = 7,
    parameter int TAP   = 6,
    parameter int WIDTH = 32
) (
    input  logic [ORDER-1:0] state_i,
    output logic [WIDTH-1:0] word_o
);
    // Step the LFSR WIDTH times, newest bit shifted in at position 0
    function automatic logic [WIDTH-1:0] unroll(input logic [ORDER-1:0] st);
        logic [ORDER-1:0] s;
        logic [WIDTH-1:0] w;
        logic             nb;
        s = st;
        w = '0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            nb   = s[ORDER-1] ^ s[TAP-1];
            w[i] = nb;
            s    = {s[ORDER-2:0], nb};
        end
        return w;
    endfunction

    // Prediction for the next valid word
    always_comb begin
        word_o = unroll(state_i);
    end
endmodule

// File: rtl/prbs_track_fsm.sv
// Module: prbs_track_fsm
// Purpose: lock acquisition, full-period sweep and done tracking.
// It holds the predictor seed. While hunting or sweeping, the seed is taken
// from the data. Once done, it is taken from the prediction.
// Assumes clear_i is synchronous to clk and overrides any word in its cycle.
module prbs_track_fsm
    import prbs_pkg::*;
#(
    parameter int ORDER      = 7,
    parameter int WIDTH      = 32,
    parameter int LOCK_WORDS = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             valid_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic [WIDTH-1:0] pred_i,
    output logic [ORDER-1:0] seed_o,
    output logic             done_o,
    output logic             mismatch_hit_o
);
    localparam int PERIOD_BITS  = (2 ** ORDER) - 1;
    localparam int PERIOD_WORDS = (PERIOD_BITS + WIDTH - 1) / WIDTH;
    localparam int LCW          = $clog2(LOCK_WORDS + 1);
    localparam int PCW          = $clog2(PERIOD_WORDS + 1);

    phase_t           phase_q;
    logic             seeded_q;
    logic [LCW-1:0]   lock_cnt_q;
    logic [PCW-1:0]   per_cnt_q;
    logic [ORDER-1:0] seed_q;
    logic             match;

    // Whole-word compare, so a word yields at most one event
    assign match = (data_i == pred_i);

    // Phase, counters and seed update, one step per valid word
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            phase_q    <= PH_HUNT;
            seeded_q   <= 1'b0;
            lock_cnt_q <= '0;
            per_cnt_q  <= '0;
            seed_q     <= '0;
        end else if (valid_i) begin
            unique case (phase_q)
                PH_HUNT: begin
                    seed_q   <= data_i[ORDER-1:0];
                    seeded_q <= 1'b1;
                    if (seeded_q && match) begin
                        if (lock_cnt_q == LCW'(LOCK_WORDS - 1)) begin
                            phase_q    <= PH_SWEEP;
                            lock_cnt_q <= '0;
                            per_cnt_q  <= '0;
                        end else begin
                            lock_cnt_q <= lock_cnt_q + 1'b1;
                        end
                    end else begin
                        lock_cnt_q <= '0;
                    end
                end
                PH_SWEEP: begin
                    seed_q <= data_i[ORDER-1:0];
                    if (!match) begin
                        phase_q    <= PH_HUNT;
                        lock_cnt_q <= '0;
                    end else if (per_cnt_q == PCW'(PERIOD_WORDS - 1)) begin
                        phase_q <= PH_DONE;
                    end else begin
                        per_cnt_q <= per_cnt_q + 1'b1;
                    end
                end
                PH_DONE: begin
                    seed_q <= pred_i[ORDER-1:0];
                end
                default: phase_q <= PH_HUNT;
            endcase
        end
    end

    assign seed_o         = seed_q;
    assign done_o         = (phase_q == PH_DONE);
    assign mismatch_hit_o = valid_i && !clear_i && (phase_q == PH_DONE) && !match;
endmodule

// File: rtl/prbs_err_stretch.sv
// Module: prbs_err_stretch
// Purpose: turns a one-cycle error strobe into a pulse LENGTH cycles long.
// A new strobe during a pulse restarts the count. clear_i cancels the pulse.
// Assumes LENGTH >= 1.
module prbs_err_stretch #(
    parameter int LENGTH = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic hit_i,
    output logic pulse_o
);
    localparam int CW = $clog2(LENGTH + 1);

    logic [CW-1:0] cnt_q;

    // Load on a hit, count down otherwise
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) begin
            cnt_q <= '0;
        end else if (hit_i) begin
            cnt_q <= CW'(LENGTH);
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign pulse_o = (cnt_q != '0);
endmodule

// File: rtl/prbs_verifier.sv
// Module: prbs_verifier (top)
// Purpose: parallel PRBS verifier. It locks to the incoming pattern, verifies
// one full period, then reports each errored word as a stretched pulse.
// Assumes all inputs are synchronous to clk. The polynomial is
// x^ORDER + x^TAP + 1, and the MSB of a word is the earliest bit.
module prbs_verifier #(
    parameter int ORDER      = 7,
    parameter int TAP        = 6,
    parameter int WIDTH      = 32,
    parameter int LOCK_WORDS = 4,
    parameter int ERR_CYCLES = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             valid_i,
    input  logic [WIDTH-1:0] data_i,
    input  logic             clear_i,
    output logic             done_o,
    output logic             error_o
);
    logic [ORDER-1:0] seed;
    logic [WIDTH-1:0] pred;
    logic             hit;

    prbs_predictor #(.ORDER(ORDER), .TAP(TAP), .WIDTH(WIDTH)) u_pred (
        .state_i (seed),
        .word_o  (pred)
    );

    prbs_track_fsm #(.ORDER(ORDER), .WIDTH(WIDTH), .LOCK_WORDS(LOCK_WORDS)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .clear_i        (clear_i),
        .valid_i        (valid_i),
        .data_i         (data_i),
        .pred_i         (pred),
        .seed_o         (seed),
        .done_o         (done_o),
        .mismatch_hit_o (hit)
    );

    prbs_err_stretch #(.LENGTH(ERR_CYCLES)) u_err (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear_i),
        .hit_i   (hit),
        .pulse_o (error_o)
    );
endmodule

// File: rtl/prbs_verifier_chk.sv
// Module: prbs_verifier_chk
// Purpose: temporal properties on the verifier ports, bound to the top.
// Assumes the default pulse length of 3 cycles.
module prbs_verifier_chk (
    input logic clk,
    input logic rst_n,
    input logic valid_i,
    input logic clear_i,
    input logic done_o,
    input logic error_o
);
    p_no_err_before_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |=> !error_o);

    p_err_only_with_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
        error_o |-> done_o);

    p_pulse_min_len_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(error_o) && !clear_i) |=> (error_o && !clear_i) ##1 error_o);

    p_done_needs_word_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done_o) |-> $past(valid_i));

    p_done_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !clear_i) |=> done_o);

    p_clear_drops_r10: assert property (@(posedge clk) disable iff (!rst_n)
        clear_i |=> (!done_o && !error_o));

    p_idle_no_rise_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !valid_i |=> !$rose(done_o));
endmodule

bind prbs_verifier prbs_verifier_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid_i (valid_i),
    .clear_i (clear_i),
    .done_o  (done_o),
    .error_o (error_o)
);

// File: tb/prbs_verifier_tb_top.sv
module prbs_verifier_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        valid = 1'b0;
    logic [31:0] data = '0;
    logic        clr = 1'b0;
    logic        done_w;
    logic        err_w;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;
    logic [6:0] bst = 7'h5A;

    always #2 clk = ~clk;

    prbs_verifier dut_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .valid_i (valid),
        .data_i  (data),
        .clear_i (clr),
        .done_o  (done_w),
        .error_o (err_w)
    );

    // Bench model of the stream: b[n] = b[n-7] ^ b[n-6], MSB first
    function automatic logic [31:0] gen(inout logic [6:0] st);
        logic [31:0] w;
        for (int i = 31; i >= 0; i--) begin
            w[i] = st[6] ^ st[5];
            st   = {st[5:0], w[i]};
        end
        return w;
    endfunction

    task automatic chk(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%b expected=%b t=%0t", req, act, exp, $time);
        end
    endtask

    task automatic put(input logic v, input logic [31:0] d, input logic c);
        @(negedge clk);
        valid = v;
        data  = d;
        clr   = c;
        @(posedge clk);
        #1;
    endtask

    task automatic good();
        put(1'b1, gen(bst), 1'b0);
    endtask

    task automatic idle();
        put(1'b0, $urandom, 1'b0);
    endtask

    // Send n good words with random valid-low gaps; check done stays low until the last
    task automatic lock_run(input int n, input string req);
        for (int k = 0; k < n; k++) begin
            if ($urandom_range(0, 3) == 0) begin
                idle();
                chk({req, " gap"}, done_w, 1'b0);
            end
            good();
            chk(req, done_w, (k == n - 1));
            chk({req, " R5 err"}, err_w, 1'b0);
        end
    endtask

    // Errored word, then observe the pulse cycle by cycle with idles
    task automatic err_pulse(input logic [31:0] flip, input string req);
        logic [31:0] w;
        w = gen(bst);
        put(1'b1, w ^ flip, 1'b0);
        chk(req, err_w, 1'b1);
        idle(); chk(req, err_w, 1'b1);
        good(); chk(req, err_w, 1'b1);
        good(); chk(req, err_w, 1'b0);
        chk({req, " done held"}, done_w, 1'b1);
    endtask

    initial begin
        logic [31:0] w;
        void'($urandom(32'd1234));
        repeat (3) @(posedge clk);
        #1;
        chk("R1 done", done_w, 1'b0);
        chk("R1 error", err_w, 1'b0);
        @(negedge clk); rst_n = 1'b1;

        // R2 + R9: first lock, 9 good words with random idle gaps
        lock_run(9, "R2 lock");

        // R9: random mix of good words and valid-low garbage, no error
        for (int k = 0; k < 200; k++) begin
            if ($urandom_range(0, 1) == 1) good(); else idle();
            chk("R9 no error", err_w, 1'b0);
        end
        chk("R9 done", done_w, 1'b1);

        // R6: single bit error
        err_pulse(32'h0001_0000, "R6 pulse");
        // R7: every bit wrong, still one pulse, then clean words
        err_pulse(32'hFFFF_FFFF, "R7 all bits");
        for (int k = 0; k < 20; k++) begin
            good();
            chk("R7 no repeat", err_w, 1'b0);
        end

        // R8: retrigger during pulse -> 5 high cycles total
        put(1'b1, gen(bst) ^ 32'h8, 1'b0); chk("R8 c1", err_w, 1'b1);
        idle();                             chk("R8 c2", err_w, 1'b1);
        put(1'b1, gen(bst) ^ 32'h4, 1'b0); chk("R8 c3", err_w, 1'b1);
        idle();                             chk("R8 c4", err_w, 1'b1);
        idle();                             chk("R8 c5", err_w, 1'b1);
        idle();                             chk("R8 c6", err_w, 0);

        // R10: clear during an active pulse
        put(1'b1, gen(bst) ^ 32'h1, 1'b0);
        chk("R10 pre", err_w, 1'b1);
        put(1'b0, '0, 1'b1);
        chk("R10 done", done_w, 1'b0);
        chk("R10 error", err_w, 1'b0);
        lock_run(9, "R10 relock");

        // R11: word with clear is discarded, so 9 more words needed
        put(1'b1, gen(bst), 1'b1);
        chk("R11 done", done_w, 1'b0);
        lock_run(9, "R11 relock");

        // R3: mismatch while hunting; bit 31 flip keeps low bits as seed
        put(1'b0, '0, 1'b1);
        good(); good(); good();
        w = gen(bst);
        put(1'b1, w ^ 32'h8000_0000, 1'b0);
        chk("R3 err", err_w, 1'b0);
        lock_run(8, "R3 reseed");

        // R4: mismatch while sweeping the period
        put(1'b0, '0, 1'b1);
        for (int k = 0; k < 7; k++) good();
        chk("R4 pre", done_w, 1'b0);
        w = gen(bst);
        put(1'b1, w ^ 32'h8000_0000, 1'b0);
        chk("R4 no err", err_w, 1'b0);
        chk("R4 done", done_w, 1'b0);
        lock_run(8, "R4 reseed");

        idle();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=hung expected=complete");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule